// File: doc/BRIEF.md
# Page-Table Walker

This block turns a virtual address into a physical address. It reads one entry from a flat page table held in physical memory. A requester presents a virtual address, a write flag and a strobe. The block splits the address into a virtual page number and a page offset. It forms the entry address as the table base plus the page number times the entry size, and issues one read on its memory port. It then answers with either a physical address or a fault.

When the entry is present, the physical address is the frame number from the entry with the untouched page offset below it. On every successful translation the referenced status bit is set. On a write request the modified bit is set as well. The updated entry is stored back only if one of the two bits actually changed.

Entry layout in a data word: bit 0 present, bit 1 referenced, bit 2 modified, and the frame number in the bits from bit 3 upward. The control is a five-state machine:
- IDLE moves to FETCH on an accepted request (`req_valid` while `req_ready`).
- FETCH moves to EVAL when the read completes (`mem_ready`).
- EVAL moves to STORE when a status bit must change, and otherwise to REPLY. A fault or an unchanged entry takes the REPLY path.
- STORE moves to REPLY when the write completes.
- REPLY returns to IDLE after one cycle.

Top module: `ptw_top`

## Requirements
- R1: After reset, `req_ready` is 1 and both `rsp_valid` and `mem_valid` are 0.
- R2: An accepted request issues exactly one read, at address `ptbase + VPN*4`. The VPN is `req_va[15:12]` at the default sizes (4 KB pages, 4-byte entries).
- R3: An entry whose present bit (bit 0) is 0 gives `rsp_fault`=1 and `rsp_pa`=0. No write is issued and the entry is left unchanged.
- R4: For a present entry, `rsp_fault`=0 and `rsp_pa` is the frame number (entry bits 10:3 by default) times the page size plus the page offset (`req_va[11:0]`).
- R5: A successful read request sets the referenced bit (bit 1) through one write-back. No write is issued if that bit was already set.
- R6: A successful write request leaves both the referenced bit and the modified bit (bit 2) set. The write-back goes to the entry's own address, keeps the frame and present bits, and is skipped if both bits were already set.
- R7: While a request is in progress, `req_ready` is 0, and any strobe on `req_valid` is ignored: it causes no extra memory access.
- R8: A memory request holds `mem_valid`, `mem_addr` and `mem_write` steady until `mem_ready` is seen.
- R9: Each accepted request yields exactly one `rsp_valid` pulse, one cycle long.
- R10: `ptbase` is sampled when a request is accepted. Changing it during a walk does not change that walk's entry address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ptbase | input | PA_W | Physical start address of the page table |
| req_valid | input | 1 | Translation request strobe |
| req_va | input | VA_W | Virtual address to translate |
| req_write | input | 1 | Request is a store access |
| req_ready | output | 1 | Block is idle and accepts a request |
| rsp_valid | output | 1 | One-cycle result pulse |
| rsp_fault | output | 1 | Entry not present |
| rsp_pa | output | PA_W | Translated physical address |
| mem_valid | output | 1 | Memory request pending |
| mem_write | output | 1 | Pending request is a write |
| mem_addr | output | PA_W | Entry byte address |
| mem_wdata | output | DATA_W | Updated entry for write-back |
| mem_ready | input | 1 | Memory completes the pending request this cycle |
| mem_rdata | input | DATA_W | Entry read data, valid with `mem_ready` on a read |

## Verification
Some properties are checked on every cycle:
- the memory request stays stable across wait states;
- the response is a single-cycle pulse;
- `req_ready` is low whenever memory is being accessed;
- any write-back carries the present and referenced bits;
- the fault flag matches the present bit of the entry last read.

Only the bench's scenarios can show the rest:
- the arithmetic of the entry address and the physical address;
- the choice between skipping and issuing a write-back, depending on the prior status bits;
- that strobes and base changes during a walk leave that walk unaffected.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_EVAL,
        ST_STORE,
        ST_REPLY
    } ptw_state_t;

    localparam int PRES_BIT  = 0;
    localparam int REF_BIT   = 1;
    localparam int MOD_BIT   = 2;
    localparam int FRAME_LSB = 3;

endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
    parameter int PA_W        = 20,
    parameter int VPN_W       = 4,
    parameter int ENTRY_SHIFT = 2
) (
    input  logic [PA_W-1:0]  base,
    input  logic [VPN_W-1:0] vpn,
    output logic [PA_W-1:0]  entry_addr
);
    logic [PA_W-1:0] scaled;

    always_comb begin
        scaled     = PA_W'(vpn) << ENTRY_SHIFT;
        entry_addr = base + scaled;
    end
endmodule

// File: rtl/ptw_entry_upd.sv
module ptw_entry_upd
    import ptw_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int PFN_W  = 8,
    parameter int OFS_W  = 12
) (
    input  logic [DATA_W-1:0]      entry,
    input  logic                   is_write,
    input  logic [OFS_W-1:0]       offset,
    output logic                   present,
    output logic [PFN_W+OFS_W-1:0] phys,
    output logic [DATA_W-1:0]      new_entry,
    output logic                   need_store
);
    logic [PFN_W-1:0]  frame;
    logic [DATA_W-1:0] set_mask;

    always_comb begin
        present  = entry[PRES_BIT];
        frame    = entry[FRAME_LSB +: PFN_W];
        phys     = {frame, offset};
        set_mask = '0;
        set_mask[REF_BIT] = 1'b1;
        set_mask[MOD_BIT] = is_write;
        new_entry  = entry | set_mask;
        need_store = present && (new_entry != entry);
    end
endmodule

// File: rtl/ptw_top.sv
module ptw_top
    import ptw_pkg::*;
#(
    parameter int VA_W        = 16,
    parameter int PA_W        = 20,
    parameter int PAGE_BYTES  = 4096,
    parameter int DATA_W      = 32,
    parameter int ENTRY_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PA_W-1:0]   ptbase,
    input  logic              req_valid,
    input  logic [VA_W-1:0]   req_va,
    input  logic              req_write,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic              rsp_fault,
    output logic [PA_W-1:0]   rsp_pa,
    output logic              mem_valid,
    output logic              mem_write,
    output logic [PA_W-1:0]   mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ready,
    input  logic [DATA_W-1:0] mem_rdata
);
    localparam int OFS_W       = $clog2(PAGE_BYTES);
    localparam int VPN_W       = VA_W - OFS_W;
    localparam int PFN_W       = PA_W - OFS_W;
    localparam int ENTRY_SHIFT = $clog2(ENTRY_BYTES);

    ptw_state_t        state, state_nx;
    logic [OFS_W-1:0]  ofs_q;
    logic              wr_q;
    logic [PA_W-1:0]   addr_q;
    logic [DATA_W-1:0] pte_q;
    logic              fault_q;
    logic [PA_W-1:0]   pa_q;

    logic [PA_W-1:0]   entry_addr;
    logic              present;
    logic [PA_W-1:0]   phys;
    logic [DATA_W-1:0] new_entry;
    logic              need_store;

    ptw_addr_gen #(
        .PA_W        (PA_W),
        .VPN_W       (VPN_W),
        .ENTRY_SHIFT (ENTRY_SHIFT)
    ) u_addr (
        .base       (ptbase),
        .vpn        (req_va[VA_W-1:OFS_W]),
        .entry_addr (entry_addr)
    );

    ptw_entry_upd #(
        .DATA_W (DATA_W),
        .PFN_W  (PFN_W),
        .OFS_W  (OFS_W)
    ) u_upd (
        .entry      (pte_q),
        .is_write   (wr_q),
        .offset     (ofs_q),
        .present    (present),
        .phys       (phys),
        .new_entry  (new_entry),
        .need_store (need_store)
    );

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (req_valid) state_nx = ST_FETCH;
            ST_FETCH: if (mem_ready) state_nx = ST_EVAL;
            ST_EVAL:  state_nx = need_store ? ST_STORE : ST_REPLY;
            ST_STORE: if (mem_ready) state_nx = ST_REPLY;
            ST_REPLY: state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // walk data registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ofs_q   <= '0;
            wr_q    <= 1'b0;
            addr_q  <= '0;
            pte_q   <= '0;
            fault_q <= 1'b0;
            pa_q    <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (req_valid) begin
                    ofs_q  <= req_va[OFS_W-1:0];
                    wr_q   <= req_write;
                    addr_q <= entry_addr;
                end
                ST_FETCH: if (mem_ready) pte_q <= mem_rdata;
                ST_EVAL: begin
                    fault_q <= !present;
                    pa_q    <= present ? phys : '0;
                    pte_q   <= new_entry;
                end
                default: ;
            endcase
        end
    end

    // outputs decoded from state
    always_comb begin
        req_ready = 1'b0;
        mem_valid = 1'b0;
        mem_write = 1'b0;
        rsp_valid = 1'b0;
        unique case (state)
            ST_IDLE:  req_ready = 1'b1;
            ST_FETCH: mem_valid = 1'b1;
            ST_EVAL:  ;
            ST_STORE: begin
                mem_valid = 1'b1;
                mem_write = 1'b1;
            end
            ST_REPLY: rsp_valid = 1'b1;
            default:  ;
        endcase
        mem_addr  = addr_q;
        mem_wdata = pte_q;
        rsp_fault = fault_q;
        rsp_pa    = pa_q;
    end
endmodule

// File: rtl/ptw_chk.sv
module ptw_chk
    import ptw_pkg::*;
#(
    parameter int PA_W   = 20,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic              rsp_fault,
    input logic              mem_valid,
    input logic              mem_write,
    input logic [PA_W-1:0]   mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              mem_ready,
    input logic [DATA_W-1:0] mem_rdata
);
    logic seen_present;

    always_ff @(posedge clk) begin
        if (!rst_n)                                 seen_present <= 1'b0;
        else if (mem_valid && !mem_write && mem_ready) seen_present <= mem_rdata[PRES_BIT];
    end

    // R8
    hold_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_write));

    // R9
    one_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R7
    busy_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid || rsp_valid) |-> !req_ready);

    // R3
    fault_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_fault == !seen_present));

    // R6
    store_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && mem_write |-> mem_wdata[PRES_BIT] && mem_wdata[REF_BIT]);
endmodule

bind ptw_top ptw_chk #(.PA_W(PA_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .rsp_fault (rsp_fault),
    .mem_valid (mem_valid),
    .mem_write (mem_write),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ready (mem_ready),
    .mem_rdata (mem_rdata)
);

// File: tb/sim_ptw_top.sv
module sim_ptw_top;
    localparam int CLK_NS = 10;
    localparam logic [19:0] TBL = 20'h01000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [19:0] ptbase = TBL;
    logic        req_valid = 1'b0;
    logic [15:0] req_va = '0;
    logic        req_write = 1'b0;
    logic        req_ready, rsp_valid, rsp_fault;
    logic [19:0] rsp_pa;
    logic        mem_valid, mem_write;
    logic [19:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        mem_ready = 1'b0;
    logic [31:0] mem_rdata = '0;

    logic [31:0] mem [16];
    int mem_wait = 0, wait_cnt = 0;
    int n_reads = 0, n_writes = 0;
    logic [19:0] last_raddr = '0, last_waddr = '0;
    bit busy = 1'b0;
    bit run = 1'b0;
    int total = 0, bad = 0;

    always #(CLK_NS/2) clk = ~clk;

    ptw_top u0 (
        .clk(clk), .rst_n(rst_n), .ptbase(ptbase),
        .req_valid(req_valid), .req_va(req_va), .req_write(req_write),
        .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
        .rsp_pa(rsp_pa), .mem_valid(mem_valid), .mem_write(mem_write),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ready(mem_ready), .mem_rdata(mem_rdata)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic [7:0] frame, input bit m, input bit r, input bit p);
        return {21'b0, frame, m, r, p};
    endfunction

    // memory model: answers after mem_wait idle cycles
    always @(negedge clk) begin
        if (!rst_n) begin
            mem_ready = 1'b0;
            wait_cnt  = 0;
        end else if (mem_valid && !mem_ready) begin
            if (wait_cnt >= mem_wait) begin
                int idx;
                mem_ready = 1'b1;
                wait_cnt  = 0;
                idx = int'((mem_addr - TBL) >> 2) & 15;
                if (mem_write) begin
                    n_writes++;
                    last_waddr = mem_addr;
                    mem[idx] = mem_wdata;
                end else begin
                    n_reads++;
                    last_raddr = mem_addr;
                    mem_rdata = mem[idx];
                end
            end else begin
                wait_cnt++;
            end
        end else begin
            mem_ready = 1'b0;
        end
    end

    // reference model of acceptance, compared every clock (R7)
    always @(negedge clk) begin
        if (rst_n && run) begin
            check(req_ready == !busy, "R7 req_ready vs model", 32'(req_ready), 32'(!busy));
            if (rsp_valid) busy = 1'b0;
        end
    end
    always @(posedge clk) begin
        if (!rst_n) busy = 1'b0;
        else if (!busy && req_valid) busy = 1'b1;
    end

    task automatic xlate(input logic [15:0] va, input bit wr, input bit interfere,
                         input bit exp_fault, input logic [19:0] exp_pa,
                         input int exp_wr, input logic [31:0] exp_entry, input string tag);
        int r0, w0, idx, cyc;
        r0 = n_reads; w0 = n_writes; idx = int'(va[15:12]);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_va = va; req_write = wr;
        @(negedge clk);
        req_valid = 1'b0;
        if (interfere) begin
            ptbase = 20'h08000;
            req_valid = 1'b1; req_va = 16'hF000;
            @(negedge clk);
            req_valid = 1'b0;
        end
        cyc = 0;
        while (!rsp_valid && cyc < 200) begin @(negedge clk); cyc++; end
        ptbase = TBL;
        check(rsp_valid, {tag, " R9 response seen"}, 32'(rsp_valid), 1);
        check(rsp_fault == exp_fault, {tag, " R3/R4 fault flag"}, 32'(rsp_fault), 32'(exp_fault));
        check(rsp_pa == exp_pa, {tag, " R4 physical address"}, 32'(rsp_pa), 32'(exp_pa));
        @(negedge clk);
        check(!rsp_valid, {tag, " R9 single pulse"}, 32'(rsp_valid), 0);
        check(n_reads - r0 == 1, {tag, " R2/R7 read count"}, 32'(n_reads - r0), 1);
        check(last_raddr == TBL + 20'(idx * 4), {tag, " R2/R10 entry address"},
              32'(last_raddr), 32'(TBL + 20'(idx * 4)));
        check(n_writes - w0 == exp_wr, {tag, " R5/R6 write-back count"}, 32'(n_writes - w0), 32'(exp_wr));
        check(mem[idx] == exp_entry, {tag, " R5/R6 stored entry"}, mem[idx], exp_entry);
        if (exp_wr != 0)
            check(last_waddr == last_raddr, {tag, " R6 write-back address"}, 32'(last_waddr), 32'(last_raddr));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        check(1'b0, "watchdog expired", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) mem[i] = '0;
        mem[3]  = mk(8'h06, 0, 0, 1);
        mem[5]  = mk(8'h09, 1, 1, 0);
        mem[15] = mk(8'hFF, 0, 0, 1);
        mem[2]  = mk(8'h12, 0, 1, 1);
        repeat (3) @(negedge clk);
        check(req_ready && !rsp_valid && !mem_valid, "R1 outputs in reset",
              {29'b0, req_ready, rsp_valid, mem_valid}, 32'b100);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready && !rsp_valid && !mem_valid, "R1 outputs after reset",
              {29'b0, req_ready, rsp_valid, mem_valid}, 32'b100);
        run = 1'b1;

        // R4 frame 6, offset 4 -> 24580; R5 referenced bit set
        mem_wait = 0;
        xlate(16'h3004, 0, 0, 0, 20'd24580, 1, mk(8'h06, 0, 1, 1), "R5 first read");
        // R5 referenced already set: no write-back
        mem_wait = 2;
        xlate(16'h3123, 0, 0, 0, 20'h06123, 0, mk(8'h06, 0, 1, 1), "R5 repeat read");
        // R6 write sets modified
        xlate(16'h3FF0, 1, 0, 0, 20'h06FF0, 1, mk(8'h06, 1, 1, 1), "R6 first write");
        mem_wait = 1;
        xlate(16'h3001, 1, 0, 0, 20'h06001, 0, mk(8'h06, 1, 1, 1), "R6 repeat write");
        // R3 non-present entry
        xlate(16'h5ABC, 1, 0, 1, 20'h0, 0, mk(8'h09, 1, 1, 0), "R3 fault");
        // R4 top page, largest frame and offset; both bits set at once
        mem_wait = 0;
        xlate(16'hFFFF, 1, 0, 0, 20'hFFFFF, 1, mk(8'hFF, 1, 1, 1), "R4 boundary");
        // R7 strobe while busy and R10 base change mid-walk
        mem_wait = 4;
        xlate(16'h2ABC, 0, 1, 0, 20'h12ABC, 0, mk(8'h12, 0, 1, 1), "R7 R10 interference");
        repeat (3) @(negedge clk);
        check(req_ready, "R7 idle after walks", 32'(req_ready), 1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule